// File: doc/BRIEF.md
# Fan Drive Supervisor with Stall Detection

This block sits between a closed-loop fan speed controller and the PWM generator. On every tach sample strobe it takes the controller's requested drive byte and turns it into the final drive byte. While speed control is on, the final drive is kept at or above a programmable floor. Speed targets the fan cannot sustain are refused, and the previous drive is kept. A stalled fan is recognised from its tach count, which grows as the fan slows.

A drive-failure monitor runs while the output sits at full scale. It counts consecutive samples in which the fan stays slower than the target by more than a programmable band. When that run lasts for the selected number of samples, it sets a sticky status bit. That bit, gated by an enable, forms the interrupt. Configuration lives in four small registers behind a simple write port with a combinational read mux.

Top module: `fan_drive_supervisor`

## Requirements
- R1: After reset the floor register reads 66h (address 0), the valid-count register reads F5h (address 1), the band register reads 10h (address 2), the control register reads 00h (address 3), and the drive, spin request, status and interrupt outputs are all 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` at `cfg_addr`. Address 0 is the floor, 1 the valid count, 2 the band, and 3 the control register (bits 1:0 fail-time select, bit 2 interrupt enable, other bits read 0). `cfg_rdata` shows the addressed register in the same cycle.
- R3: The drive output changes only on a cycle with `sample_stb` high, and the new value appears one clock later. With speed control enabled, a target other than FFh and not above the valid count gives drive = max(requested, floor).
- R4: With speed control enabled and a target of FFh, the requested drive passes through with no floor applied.
- R5: With speed control enabled and a target other than FFh above the valid count, the drive output keeps its previous value.
- R6: With speed control enabled, a sample whose tach count exceeds the valid count raises `spin_req` for exactly the one cycle after the strobe.
- R7: With speed control disabled, the drive equals the requested value. `spin_req` pulses only when the previous drive was 00h and the request is nonzero. The tach count has no effect in this mode.
- R8: A sample counts as a failing sample when speed control is enabled, the drive output is FFh before the strobe, and tach > min(target + band, FFh).
- R9: Fail-time select s needs 16·2^s consecutive failing samples (16, 32, 64 or 128). The status sets on that sample. Any sample that is not failing restarts the run.
- R10: The status is sticky and clears only on a `sts_clr` pulse, and a set in the same cycle wins. `irq` equals status AND the interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fsc_en | input | 1 | Closed-loop speed control enable |
| sample_stb | input | 1 | One-cycle strobe per tach sample |
| req_drive | input | 8 | Drive requested by the controller |
| tach_cnt | input | 8 | Measured tach count (inverse of speed) |
| target_cnt | input | 8 | Target tach count |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| sts_clr | input | 1 | Write-one-to-clear pulse for the fail status |
| cfg_rdata | output | 8 | Addressed configuration register |
| drive_out | output | 8 | Final drive byte to the PWM generator |
| spin_req | output | 1 | Spin-up request pulse |
| fail_sts | output | 1 | Sticky drive-fail status |
| irq | output | 1 | Drive-fail interrupt |

## Verification
Directed cases separate the three drive paths: a request below the floor, a full-scale target with a low request, and a refused target. Each gives a different drive value, so a swapped priority shows up at once. The stall check is tried with tach counts just at and just above the valid count, and the disabled mode is tried with zero-to-nonzero and nonzero-to-nonzero drive steps. Failure runs of exactly N-1 and N samples, a run broken by one good sample, and a target where the band saturates at FFh show the duration counting and the threshold arithmetic. A long seeded random run mixes all modes against a bench model and catches interactions the directed cases miss.

// File: rtl/fds_pkg.sv
package fds_pkg;
  localparam int DW = 8;
  typedef logic [DW-1:0] dbyte_t;

  typedef enum logic [1:0] {
    ADDR_FLOOR = 2'd0,
    ADDR_VALID = 2'd1,
    ADDR_BAND  = 2'd2,
    ADDR_CTRL  = 2'd3
  } cfg_addr_e;

  localparam dbyte_t RST_FLOOR = 8'h66;
  localparam dbyte_t RST_VALID = 8'hF5;
  localparam dbyte_t RST_BAND  = 8'h10;

  function automatic dbyte_t sat_add(input dbyte_t a, input dbyte_t b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DW] ? '1 : s[DW-1:0];
  endfunction
endpackage

// File: rtl/fds_cfg_regs.sv
module fds_cfg_regs
  import fds_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] addr,
  input  dbyte_t     wdata,
  output dbyte_t     rdata,
  output dbyte_t     floor_q,
  output dbyte_t     valid_q,
  output dbyte_t     band_q,
  output logic [1:0] ftime_q,
  output logic       ien_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      floor_q <= RST_FLOOR;
      valid_q <= RST_VALID;
      band_q  <= RST_BAND;
      ftime_q <= 2'd0;
      ien_q   <= 1'b0;
    end else if (we) begin
      case (cfg_addr_e'(addr))
        ADDR_FLOOR: floor_q <= wdata;
        ADDR_VALID: valid_q <= wdata;
        ADDR_BAND:  band_q  <= wdata;
        default: begin
          ftime_q <= wdata[1:0];
          ien_q   <= wdata[2];
        end
      endcase
    end
  end

  always_comb begin
    case (cfg_addr_e'(addr))
      ADDR_FLOOR: rdata = floor_q;
      ADDR_VALID: rdata = valid_q;
      ADDR_BAND:  rdata = band_q;
      default:    rdata = {5'd0, ien_q, ftime_q};
    endcase
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    we && addr == 2'd3 |=> {ien_q, ftime_q} == $past(wdata[2:0])); // R2
endmodule

// File: rtl/fds_drive_ctrl.sv
module fds_drive_ctrl
  import fds_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   stb,
  input  logic   en,
  input  dbyte_t req,
  input  dbyte_t tach,
  input  dbyte_t tgt,
  input  dbyte_t floor_v,
  input  dbyte_t valid_v,
  output dbyte_t drive_q,
  output logic   spin_q
);
  logic   tgt_full, tgt_bad, stalled, wake;
  dbyte_t floored;

  assign tgt_full = (tgt == '1);
  assign tgt_bad  = (tgt > valid_v);
  assign stalled  = (tach > valid_v);
  assign wake     = (drive_q == '0) && (req != '0);
  assign floored  = (req < floor_v) ? floor_v : req;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= '0;
      spin_q  <= 1'b0;
    end else begin
      spin_q <= 1'b0;
      if (stb) begin
        if (en) begin
          spin_q <= stalled;
          if (tgt_full)     drive_q <= req;
          else if (!tgt_bad) drive_q <= floored;
        end else begin
          spin_q  <= wake;
          drive_q <= req;
        end
      end
    end
  end

  AST_DRIVE_FLOOR: assert property (@(posedge clk) disable iff (rst)
    stb && en && !tgt_full && !tgt_bad |=> drive_q >= $past(floor_v)); // R3
  AST_BAD_TARGET_HOLD: assert property (@(posedge clk) disable iff (rst)
    stb && en && !tgt_full && tgt_bad |=> $stable(drive_q)); // R5
  AST_SPIN_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
    spin_q |-> $past(stb)); // R6
  AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(drive_q)); // R3
endmodule

// File: rtl/fds_fail_detect.sv
module fds_fail_detect
  import fds_pkg::*;
#(
  parameter int BASE_LOG = 4,
  parameter int CNT_W    = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stb,
  input  logic       en,
  input  dbyte_t     drive,
  input  dbyte_t     tach,
  input  dbyte_t     tgt,
  input  dbyte_t     band,
  input  logic [1:0] ftime,
  input  logic       clr,
  output logic       sts_q
);
  localparam int LIM_MAX = 1 << (BASE_LOG + 3);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W:0]   run_nx, limit;
  dbyte_t           thr;
  logic             failing, hit;

  assign thr     = sat_add(tgt, band);
  assign failing = en && (drive == '1) && (tach > thr);
  assign limit   = (CNT_W+1)'(1) << (BASE_LOG + int'(ftime));
  assign run_nx  = {1'b0, run_q} + 1'b1;
  assign hit     = stb && failing && (run_nx >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      sts_q <= 1'b0;
    end else begin
      if (stb) begin
        if (!failing)  run_q <= '0;
        else if (hit)  run_q <= limit[CNT_W-1:0];
        else           run_q <= run_nx[CNT_W-1:0];
      end
      if (hit)      sts_q <= 1'b1;
      else if (clr) sts_q <= 1'b0;
    end
  end

  initial begin
    assert (LIM_MAX < (1 << CNT_W)) else $error("run counter too narrow");
  end

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    sts_q && !clr |=> sts_q); // R10
  AST_RUN_RESET_OFF: assert property (@(posedge clk) disable iff (rst)
    stb && !en |=> run_q == '0); // R8
  AST_NO_EARLY_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_q) |-> $past(stb)); // R9
endmodule

// File: rtl/fan_drive_supervisor.sv
module fan_drive_supervisor
  import fds_pkg::*;
#(
  parameter int BASE_LOG = 4,
  parameter int CNT_W    = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fsc_en,
  input  logic       sample_stb,
  input  logic [7:0] req_drive,
  input  logic [7:0] tach_cnt,
  input  logic [7:0] target_cnt,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       sts_clr,
  output logic [7:0] cfg_rdata,
  output logic [7:0] drive_out,
  output logic       spin_req,
  output logic       fail_sts,
  output logic       irq
);
  dbyte_t     floor_v, valid_v, band_v;
  logic [1:0] ftime_v;
  logic       ien_v;

  fds_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .floor_q(floor_v), .valid_q(valid_v), .band_q(band_v),
    .ftime_q(ftime_v), .ien_q(ien_v)
  );

  fds_drive_ctrl u_drv (
    .clk(clk), .rst(rst), .stb(sample_stb), .en(fsc_en), .req(req_drive),
    .tach(tach_cnt), .tgt(target_cnt), .floor_v(floor_v), .valid_v(valid_v),
    .drive_q(drive_out), .spin_q(spin_req)
  );

  fds_fail_detect #(.BASE_LOG(BASE_LOG), .CNT_W(CNT_W)) u_fail (
    .clk(clk), .rst(rst), .stb(sample_stb), .en(fsc_en), .drive(drive_out),
    .tach(tach_cnt), .tgt(target_cnt), .band(band_v), .ftime(ftime_v),
    .clr(sts_clr), .sts_q(fail_sts)
  );

  assign irq = fail_sts & ien_v;

  AST_IRQ_NEEDS_STS: assert property (@(posedge clk) disable iff (rst)
    irq |-> fail_sts && cfg_we == cfg_we); // R10
endmodule

// File: tb/fan_drive_supervisor_tb.sv
module fan_drive_supervisor_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsc_en = 1'b0, sample_stb = 1'b0, cfg_we = 1'b0, sts_clr = 1'b0;
  logic [7:0] req_drive = '0, tach_cnt = '0, target_cnt = '0, cfg_wdata = '0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_rdata, drive_out;
  logic       spin_req, fail_sts, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_floor = 8'h66, m_valid = 8'hF5, m_band = 8'h10, m_drive = 8'h00;
  logic [1:0] m_ft = 0;
  logic       m_ien = 0, m_sts = 0, m_spin = 0;
  int         m_run = 0;

  always #4 clk = ~clk;

  fan_drive_supervisor u_dut (
    .clk(clk), .rst(rst), .fsc_en(fsc_en), .sample_stb(sample_stb),
    .req_drive(req_drive), .tach_cnt(tach_cnt), .target_cnt(target_cnt),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .sts_clr(sts_clr),
    .cfg_rdata(cfg_rdata), .drive_out(drive_out), .spin_req(spin_req),
    .fail_sts(fail_sts), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int thr_of(input int tgt, input int band);
    return (tgt + band > 255) ? 255 : tgt + band;
  endfunction

  task automatic model_step(input bit en, input int req, input int tach, input int tgt);
    bit failing;
    failing = en && m_drive == 8'hFF && tach > thr_of(tgt, m_band);
    if (failing) begin
      m_run++;
      if (m_run >= (16 << m_ft)) begin m_sts = 1; m_run = 16 << m_ft; end
    end else m_run = 0;
    if (en) begin
      m_spin = tach > m_valid;
      if (tgt == 255) m_drive = req[7:0];
      else if (tgt <= m_valid) m_drive = (req < m_floor) ? m_floor : req[7:0];
    end else begin
      m_spin = (m_drive == 0) && (req != 0);
      m_drive = req[7:0];
    end
  endtask

  task automatic sample(input bit en, input int req, input int tach, input int tgt,
                        input string tag);
    fsc_en = en; req_drive = req[7:0]; tach_cnt = tach[7:0]; target_cnt = tgt[7:0];
    sample_stb = 1;
    @(negedge clk);
    sample_stb = 0;
    model_step(en, req, tach, tgt);
    chk({tag, " drive"}, drive_out, m_drive);
    chk({tag, " spin"}, spin_req, m_spin);
    chk({tag, " sts"}, fail_sts, m_sts);
    chk({tag, " irq"}, irq, m_sts & m_ien);
  endtask

  task automatic cfg_write(input int a, input int d);
    cfg_addr = a[1:0]; cfg_wdata = d[7:0]; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    case (a)
      0: m_floor = d[7:0];
      1: m_valid = d[7:0];
      2: m_band = d[7:0];
      default: begin m_ft = d[1:0]; m_ien = d[2]; end
    endcase
  endtask

  task automatic clear_sts();
    sts_clr = 1;
    @(negedge clk);
    sts_clr = 0;
    m_sts = 0;
    chk("R10 clear", fail_sts, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset values
    cfg_addr = 0; #1 chk("R1 floor", cfg_rdata, 8'h66);
    cfg_addr = 1; #1 chk("R1 valid", cfg_rdata, 8'hF5);
    cfg_addr = 2; #1 chk("R1 band", cfg_rdata, 8'h10);
    cfg_addr = 3; #1 chk("R1 ctrl", cfg_rdata, 8'h00);
    chk("R1 drive", drive_out, 0);
    chk("R1 spin", spin_req, 0);
    chk("R1 sts", {fail_sts, irq}, 0);
    @(negedge clk);
    // R2 register writes
    cfg_write(3, 8'hFC);
    cfg_addr = 3; #1 chk("R2 ctrl readback", cfg_rdata, 8'h04);
    cfg_write(0, 8'h40);
    cfg_addr = 0; #1 chk("R2 floor readback", cfg_rdata, 8'h40);
    // R3 floor applies
    sample(1, 8'h10, 8'h20, 8'h80, "R3 floor");
    chk("R3 floor value", drive_out, 8'h40);
    sample(1, 8'h90, 8'h20, 8'h80, "R3 above floor");
    chk("R3 pass value", drive_out, 8'h90);
    // R4 target FFh bypasses floor
    sample(1, 8'h05, 8'h20, 8'hFF, "R4 full target");
    chk("R4 unfloored", drive_out, 8'h05);
    // R5 bad target holds
    sample(1, 8'h70, 8'h20, 8'hF6, "R5 bad target");
    chk("R5 held", drive_out, 8'h05);
    // R6 stall at and above threshold
    sample(1, 8'h70, 8'hF5, 8'h80, "R6 at limit");
    chk("R6 no spin at limit", spin_req, 0);
    sample(1, 8'h70, 8'hF6, 8'h80, "R6 stall");
    chk("R6 spin pulse", spin_req, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", spin_req, 0);
    // R7 disabled mode
    sample(0, 8'h00, 8'hFF, 8'h80, "R7 to zero");
    chk("R7 zero no spin", spin_req, 0);
    sample(0, 8'h22, 8'hFF, 8'h80, "R7 wake");
    chk("R7 wake spin", spin_req, 1);
    sample(0, 8'h33, 8'hFF, 8'h80, "R7 no rewake");
    chk("R7 drive follows", drive_out, 8'h33);
    // R8/R9 failure run: select 0 -> 16 samples, threshold 80h+10h
    sample(1, 8'hFF, 8'h20, 8'h80, "R8 go full");
    for (int i = 0; i < 15; i++) sample(1, 8'hFF, 8'h91, 8'h80, "R9 run");
    chk("R9 not yet", fail_sts, 0);
    sample(1, 8'hFF, 8'h90, 8'h80, "R8 at threshold is good");
    for (int i = 0; i < 15; i++) sample(1, 8'hFF, 8'h91, 8'h80, "R9 rerun");
    chk("R9 restarted", fail_sts, 0);
    sample(1, 8'hFF, 8'h91, 8'h80, "R9 sixteenth");
    chk("R9 set", fail_sts, 1);
    chk("R10 irq", irq, 1);
    // R10 set wins over clear
    sts_clr = 1; sample(1, 8'hFF, 8'h91, 8'h80, "R10 set wins");
    sts_clr = 0;
    clear_sts();
    // R8 saturated threshold: F0h+20h -> FFh, tach cannot exceed
    cfg_write(2, 8'h20);
    cfg_write(1, 8'hFF);
    for (int i = 0; i < 20; i++) sample(1, 8'hFF, 8'hFF, 8'hF0, "R8 saturate");
    chk("R8 saturated no fail", fail_sts, 0);
    // R9 select 1 -> 32 samples
    cfg_write(3, 8'h01);
    for (int i = 0; i < 31; i++) sample(1, 8'hFF, 8'hC0, 8'h40, "R9 sel1");
    chk("R9 sel1 not yet", fail_sts, 0);
    sample(1, 8'hFF, 8'hC0, 8'h40, "R9 sel1 last");
    chk("R9 sel1 set, irq off", {fail_sts, irq}, 2'b10);
    clear_sts();
    // random phase
    cfg_write(1, 8'hF5); cfg_write(2, 8'h08); cfg_write(3, 8'h04);
    for (int i = 0; i < 3000; i++) begin
      int r, req, tach, tgt;
      bit en;
      r = $urandom_range(0, 99);
      en = r < 85;
      req = (r < 60) ? 255 : $urandom_range(0, 255);
      tgt = (r % 7 == 0) ? 255 : $urandom_range(0, 250);
      tach = (r < 70) ? $urandom_range(tgt, 255) : $urandom_range(0, 255);
      if ($urandom_range(0, 199) == 0) cfg_write(0, $urandom_range(0, 255));
      if ($urandom_range(0, 299) == 0) clear_sts();
      sample(en, req, tach, tgt, "R3-R10 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule